// File: doc/BRIEF.md
# Cache Miss Category Classifier

This block watches the access stream of a small direct-mapped cache and labels every access with its outcome: a hit, or a miss of one of three kinds. A miss on a block that has never been referenced is compulsory. A miss on a block that a fully associative cache of the same size, using least-recently-used replacement, would also have lost is a capacity miss. Every other miss is a conflict miss, caused only by the single-frame mapping. Only tags and classification are modelled. There is no data storage, no write handling and no fill path.

Three structures are kept side by side. The first is the real direct-mapped tag array, where every miss overwrites the frame picked by the index bits. The second is a history bit for each block address, which is set on first reference. The third is a recency-ordered shadow directory that holds the most recent distinct blocks, with as many entries as the cache has frames. The shadow is refreshed on every access. A preload port installs a block into its frame and marks it as seen, without producing a result, so that a known starting state can be rebuilt before a run.

With the default parameters the block uses 8-bit byte addresses, a 32-byte cache and 4-byte blocks. That gives 8 frames, 2 offset bits, 3 index bits and 3 tag bits.

Top module: `miss3c_classifier`

## Requirements
- R1: After reset, `res_valid` is 0, no frame is valid, no block is marked seen and the shadow is empty, so the first access to any block reports compulsory.
- R2: `res_valid` is 1 exactly in the cycle after a cycle with `acc_valid` high, and 0 otherwise. Preload operations never raise it.
- R3: `res_code` is 2'b00 (hit) when the frame selected by address bits [4:2] is valid and holds tag bits [7:5] of the access.
- R4: `res_code` is 2'b01 (compulsory) on a miss whose block address (bits [7:2]) has never been accessed or preloaded since reset.
- R5: `res_code` is 2'b10 (capacity) on a miss to a seen block that is not among the 8 most recently referenced distinct blocks.
- R6: `res_code` is 2'b11 (conflict) on a miss to a seen block that is among the 8 most recently referenced distinct blocks.
- R7: A miss replaces the contents of the frame at its index, so an immediate repeat access to the same block hits.
- R8: Every access, hit or miss, makes its block the most recently referenced one in the shadow.
- R9: A preload (`pre_valid` high with `acc_valid` low) writes the block of `pre_addr` into its frame, marks it seen and makes it most recent. When `acc_valid` is high in the same cycle, the preload is ignored.
- R10: The two offset bits [1:0] do not take part in lookup, so two bytes of the same block behave as one block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | ADDR_W | Byte address of the access |
| pre_valid | input | 1 | Preload request, honoured only when `acc_valid` is low |
| pre_addr | input | ADDR_W | Byte address of the block to preload |
| res_valid | output | 1 | Result strobe, one cycle after `acc_valid` |
| res_code | output | 2 | 00 hit, 01 compulsory, 10 capacity, 11 conflict |

## Verification
The outcome that is hardest to reach from the ports is telling capacity apart from conflict. Both need a block that was seen, then displaced from its direct-mapped frame, and then either kept in or pushed out of the 8 most recent distinct blocks. Preload makes the starting frames and recency order exactly known. A directed sequence then walks through every outcome in turn. After that, random streams drawn from a pool of 16 blocks, two per index, give each frame repeated evictions while the distinct-block distance hovers around 8. A behavioural queue model in the bench predicts every cycle.

// File: rtl/mc3_pkg.sv
package mc3_pkg;
   typedef enum logic [1:0] {
      MC_HIT        = 2'b00,
      MC_COMPULSORY = 2'b01,
      MC_CAPACITY   = 2'b10,
      MC_CONFLICT   = 2'b11
   } miss_kind_t;
endpackage

// File: rtl/mc3_dm_tags.sv
module mc3_dm_tags #(
   parameter int FRAMES = 8,
   parameter int IDX_W  = 3,
   parameter int TAG_W  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] lk_idx,
   input  logic [TAG_W-1:0] lk_tag,
   output logic             lk_hit,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag
);
   logic [FRAMES-1:0] vld_q;
   logic [TAG_W-1:0]  tag_q [FRAMES];

   always_comb lk_hit = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);

   for (genvar f = 0; f < FRAMES; f++) begin : g_frame
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q[f] <= 1'b0;
            tag_q[f] <= '0;
         end else if (wr_en && (wr_idx == IDX_W'(f))) begin
            vld_q[f] <= 1'b1;
            tag_q[f] <= wr_tag;
         end
      end
   end

   // R7: a written frame holds the new tag on the next cycle
   a_r7_frame_filled: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (vld_q[$past(wr_idx)] && tag_q[$past(wr_idx)] == $past(wr_tag)));
endmodule

// File: rtl/mc3_seen_history.sv
module mc3_seen_history #(
   parameter int BLK_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [BLK_W-1:0] lk_blk,
   output logic             lk_seen,
   input  logic             mark_en,
   input  logic [BLK_W-1:0] mark_blk
);
   localparam int HIST_N = 1 << BLK_W;

   logic [HIST_N-1:0] seen_q;

   always_comb lk_seen = seen_q[lk_blk];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       seen_q <= '0;
      else if (mark_en) seen_q[mark_blk] <= 1'b1;
   end

   // R4: once marked, a block stays seen
   a_r4_seen_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      mark_en |=> seen_q[$past(mark_blk)]);
endmodule

// File: rtl/mc3_lru_shadow.sv
module mc3_lru_shadow #(
   parameter int DEPTH = 8,
   parameter int BLK_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [BLK_W-1:0] lk_blk,
   output logic             lk_present,
   input  logic             upd_en
);
   localparam int POS_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [BLK_W-1:0] ent_q [DEPTH];
   logic [DEPTH-1:0] vld_q;
   logic [DEPTH-1:0] match;
   logic [POS_W-1:0] pos;

   always_comb begin
      for (int i = 0; i < DEPTH; i++) match[i] = vld_q[i] && (ent_q[i] == lk_blk);
      lk_present = |match;
      pos = POS_W'(DEPTH - 1);
      for (int i = DEPTH - 1; i >= 0; i--) if (match[i]) pos = POS_W'(i);
   end

   // slot 0 is most recent; entries above the hit (or the whole stack) slide down
   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      if (i == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_q[0] <= 1'b0;
               ent_q[0] <= '0;
            end else if (upd_en) begin
               vld_q[0] <= 1'b1;
               ent_q[0] <= lk_blk;
            end
         end
      end else begin : g_body
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_q[i] <= 1'b0;
               ent_q[i] <= '0;
            end else if (upd_en && (int'(pos) >= i)) begin
               vld_q[i] <= vld_q[i-1];
               ent_q[i] <= ent_q[i-1];
            end
         end
      end
   end

   // R8: updated block sits at the most recent slot next cycle
   a_r8_mru_head: assert property (@(posedge clk) disable iff (!rst_n)
      upd_en |=> (vld_q[0] && ent_q[0] == $past(lk_blk)));
   // R6: a block never occupies two shadow slots
   a_r6_unique_entry: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match));
endmodule

// File: rtl/miss3c_classifier.sv
module miss3c_classifier #(
   parameter int ADDR_W      = 8,
   parameter int CACHE_BYTES = 32,
   parameter int BLOCK_BYTES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              pre_valid,
   input  logic [ADDR_W-1:0] pre_addr,
   output logic              res_valid,
   output logic [1:0]        res_code
);
   import mc3_pkg::*;

   localparam int OFS_W  = $clog2(BLOCK_BYTES);
   localparam int FRAMES = CACHE_BYTES / BLOCK_BYTES;
   localparam int IDX_W  = $clog2(FRAMES);
   localparam int BLK_W  = ADDR_W - OFS_W;
   localparam int TAG_W  = BLK_W - IDX_W;

   if ((BLOCK_BYTES < 2) || ((BLOCK_BYTES & (BLOCK_BYTES - 1)) != 0)) begin : g_bad_block
      $error("BLOCK_BYTES must be a power of two of at least 2");
   end
   if ((FRAMES < 2) || ((FRAMES & (FRAMES - 1)) != 0)
       || (CACHE_BYTES % BLOCK_BYTES != 0)) begin : g_bad_frames
      $error("CACHE_BYTES / BLOCK_BYTES must be a power of two of at least 2");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("ADDR_W too small for the cache geometry");
   end

   logic [BLK_W-1:0] acc_blk, pre_blk, cur_blk;
   logic             upd_en, dm_hit, seen, in_shadow, fill_en;
   miss_kind_t       kind, kind_q;
   logic             vld_q;

   always_comb begin
      acc_blk = BLK_W'(acc_addr >> OFS_W);
      pre_blk = BLK_W'(pre_addr >> OFS_W);
      cur_blk = acc_valid ? acc_blk : pre_blk;
      upd_en  = acc_valid || pre_valid;
      fill_en = acc_valid ? !dm_hit : pre_valid;
   end

   mc3_dm_tags #(.FRAMES(FRAMES), .IDX_W(IDX_W), .TAG_W(TAG_W)) i_tags (
      .clk    (clk),
      .rst_n  (rst_n),
      .lk_idx (cur_blk[IDX_W-1:0]),
      .lk_tag (cur_blk[BLK_W-1:IDX_W]),
      .lk_hit (dm_hit),
      .wr_en  (fill_en),
      .wr_idx (cur_blk[IDX_W-1:0]),
      .wr_tag (cur_blk[BLK_W-1:IDX_W])
   );

   mc3_seen_history #(.BLK_W(BLK_W)) i_hist (
      .clk      (clk),
      .rst_n    (rst_n),
      .lk_blk   (cur_blk),
      .lk_seen  (seen),
      .mark_en  (upd_en),
      .mark_blk (cur_blk)
   );

   mc3_lru_shadow #(.DEPTH(FRAMES), .BLK_W(BLK_W)) i_shadow (
      .clk        (clk),
      .rst_n      (rst_n),
      .lk_blk     (cur_blk),
      .lk_present (in_shadow),
      .upd_en     (upd_en)
   );

   always_comb begin
      if (dm_hit)          kind = MC_HIT;
      else if (!seen)      kind = MC_COMPULSORY;
      else if (!in_shadow) kind = MC_CAPACITY;
      else                 kind = MC_CONFLICT;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q  <= 1'b0;
         kind_q <= MC_HIT;
      end else begin
         vld_q  <= acc_valid;
         if (acc_valid) kind_q <= kind;
      end
   end

   assign res_valid = vld_q;
   assign res_code  = kind_q;

   // R2: result strobe follows the access strobe by one cycle
   a_r2_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |=> res_valid);
   a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> !res_valid);
   // R3: a tag-array hit reports code 00
   a_r3_hit_code: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && dm_hit) |=> (res_code == 2'b00));
   // R4: an unseen block is always a non-hit compulsory result
   a_r4_unseen_compulsory: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !seen) |=> (res_code == 2'b01));
endmodule

// File: tb/test_miss3c_classifier.sv
module test_miss3c_classifier;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       acc_valid = 1'b0;
   logic [7:0] acc_addr = '0;
   logic       pre_valid = 1'b0;
   logic [7:0] pre_addr = '0;
   logic       res_valid;
   logic [1:0] res_code;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   miss3c_classifier i_miss3c_classifier (
      .clk(clk), .rst_n(rst_n),
      .acc_valid(acc_valid), .acc_addr(acc_addr),
      .pre_valid(pre_valid), .pre_addr(pre_addr),
      .res_valid(res_valid), .res_code(res_code)
   );

   always #10 clk = ~clk;

   // behavioural reference
   bit seen_m [64];
   bit vld_m  [8];
   int tag_m  [8];
   int lru [$];
   bit pend_v = 0;
   int pend_c = 0;

   function automatic bit lru_has(int b);
      foreach (lru[i]) if (lru[i] == b) return 1;
      return 0;
   endfunction

   task automatic touch(int b);
      for (int i = 0; i < lru.size(); i++)
         if (lru[i] == b) begin lru.delete(i); break; end
      lru.push_front(b);
      if (lru.size() > 8) void'(lru.pop_back());
   endtask

   task automatic model_reset();
      foreach (seen_m[i]) seen_m[i] = 0;
      foreach (vld_m[i]) vld_m[i] = 0;
      lru.delete();
      pend_v = 0;
   endtask

   function automatic string req_of(int c);
      case (c)
         0: return "R3";
         1: return "R4";
         2: return "R5";
         default: return "R6";
      endcase
   endfunction

   // compare pending expectation, then drive the next cycle's inputs
   task automatic step(bit av, int aaddr, bit pv, int paddr, string why = "");
      n_cmp++;
      if (res_valid !== pend_v) begin
         n_bad++;
         $display("FAIL R2 %s: res_valid got %0b exp %0b", why, res_valid, pend_v);
      end else if (pend_v && res_code !== 2'(pend_c)) begin
         n_bad++;
         $display("FAIL %s %s: res_code got %0d exp %0d", req_of(pend_c), why, res_code, pend_c);
      end
      pend_v = av;
      if (av) begin
         int b = aaddr >> 2;
         int ix = b % 8;
         if (vld_m[ix] && tag_m[ix] == b / 8) pend_c = 0;
         else if (!seen_m[b]) pend_c = 1;
         else if (!lru_has(b)) pend_c = 2;
         else pend_c = 3;
         vld_m[ix] = 1; tag_m[ix] = b / 8; seen_m[b] = 1;
         touch(b);
      end else if (pv) begin
         int b = paddr >> 2;
         vld_m[b % 8] = 1; tag_m[b % 8] = b / 8; seen_m[b] = 1;
         touch(b);
      end
      acc_valid = av; acc_addr = 8'(aaddr);
      pre_valid = pv; pre_addr = 8'(paddr);
      @(negedge clk);
   endtask

   task automatic acc(int a, string why = ""); step(1, a, 0, 0, why); endtask
   task automatic idle(); step(0, 0, 0, 0, "idle"); endtask

   function automatic int q4(int a, int b, int c, int d);
      return a * 64 + b * 16 + c * 4 + d;
   endfunction

   task automatic do_reset();
      rst_n = 0; acc_valid = 0; pre_valid = 0;
      model_reset();
      @(negedge clk); @(negedge clk);
      n_cmp++;
      if (res_valid !== 1'b0) begin
         n_bad++;
         $display("FAIL R1: res_valid in reset got %0b exp 0", res_valid);
      end
      rst_n = 1;
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run hung, got timeout exp completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin : stim
      do_reset();
      // R1: nothing seen after reset
      acc(q4(0,0,0,0), "R1 first access after reset");
      acc(q4(1,2,3,0), "R1 second block");
      idle(); idle();

      // directed walk: preload blocks 0..7 in increasing order (R9)
      do_reset();
      for (int k = 0; k < 8; k++) step(0, 0, 1, k * 4, "R9 preload");
      idle();                                  // R2: preloads give no strobe
      acc(q4(3,0,2,0), "R4 compulsory");
      acc(q4(3,0,3,0), "R4 compulsory");
      acc(q4(2,1,0,0), "R4 compulsory");
      acc(q4(0,0,1,2), "R3/R10 hit on preloaded block with offset");
      acc(q4(0,0,2,0), "R5 capacity");
      acc(q4(0,0,3,0), "R5 capacity");
      acc(q4(0,1,1,0), "R3 hit; R8 refresh");
      acc(q4(0,1,0,0), "R5 capacity");
      acc(q4(2,1,0,0), "R6 conflict");
      acc(q4(2,1,0,3), "R7 repeat hits; R10 offset");
      acc(q4(3,0,2,0), "R6 conflict");
      idle();

      // R9: preload ignored while an access is present
      do_reset();
      step(1, 8'h40, 1, 8'h84, "R9 collision");
      acc(8'h84, "R9 ignored preload stays compulsory");
      // R8: hit refreshes recency, so later miss is conflict not capacity
      acc(8'h00, "R8 setup");
      for (int k = 1; k < 8; k++) acc(k * 4 + 8'h20, "R8 fillers");
      acc(8'h00, "R8 refresh by hit?");
      acc(8'h80, "R8 evict frame 0");
      acc(8'h00, "R6/R8 refreshed block is conflict");
      idle();

      // random phase over two blocks per index
      do_reset();
      for (int n = 0; n < 3000; n++) begin
         int b = int'($urandom_range(0, 7)) + (($urandom_range(0, 1) == 1) ? 32 : 0);
         int r = int'($urandom_range(0, 9));
         if (r < 7) acc(b * 4 + int'($urandom_range(0, 3)), "random");
         else if (r == 7) step(0, 0, 1, int'($urandom_range(0, 255)), "random preload");
         else if (r == 8) step(1, b * 4, 1, int'($urandom_range(0, 255)), "random collide");
         else idle();
      end
      // random phase over the full block space
      for (int n = 0; n < 2000; n++) acc(int'($urandom_range(0, 255)), "random wide");
      idle(); idle();

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule